// File: doc/BRIEF.md
# Instruction Prefix Accumulator

This block sits at the front of an instruction decode pipe and watches a byte-serial instruction stream, one byte for each cycle in which `byte_valid_i` is high. It sorts each leading byte into a legacy prefix, an extension byte (long mode only), or the first opcode byte. Legacy prefixes are gathered into an 8-bit prefix vector. The extension byte's W, R, X and B bits are captured.

When the first opcode byte arrives, the block works out the effective operand-size code from the gathered state and the execution mode. One cycle later it presents the opcode byte, the prefix vector, the extension fields and the size code, together with a one-cycle `op_valid_o` pulse for the next decode stage. The gathering state is then empty, ready for the next instruction. The presented fields stay unchanged until the next pulse.

Top module: `pfx_accum`

## Requirements
- R1: After reset, `op_valid_o` is 0 and `op_byte_o`, `pfx_vec_o`, all extension outputs and `op_size_o` are 0.
- R2: Segment prefixes write a code into `pfx_vec_o[2:0]`: 0x2E gives 1, 0x3E gives 2, 0x26 gives 3, 0x64 gives 4, 0x65 gives 5 and 0x36 gives 6; 0 means none. When an instruction has several segment prefixes, only the last one is kept, and code 7 never appears.
- R3: Each of the following prefixes sets its own flag bit and never clears another bit: 0x66 operand size sets bit 3, 0x67 address size sets bit 4, 0xF0 lock sets bit 5, 0xF3 rep sets bit 6, and 0xF2 repne sets bit 7.
- R4: When `mode_i`=2 (long mode), `op_size_o` is 3 if an extension byte with W set was captured. Otherwise it is 1 when bit 3 of the vector is set, and 2 in all other cases. W takes priority over 0x66.
- R5: When `mode_i`=1 (32-bit default), `op_size_o` is 1 if bit 3 of the vector is set and 2 otherwise. `mode_i`=3 behaves the same way.
- R6: When `mode_i`=0 (16-bit default), `op_size_o` is 2 if bit 3 of the vector is set and 1 otherwise.
- R7: In long mode, a byte from 0x40 to 0x4F is captured as the extension byte. It sets `rex_present_o`, and its bits 3, 2, 1 and 0 drive `rex_w_o`, `rex_r_o`, `rex_x_o` and `rex_b_o`. A later extension byte replaces an earlier one. In other modes, a byte in this range is an opcode.
- R8: A valid non-prefix byte produces `op_valid_o` high for exactly the next cycle, with `op_byte_o` equal to that byte. Back-to-back opcode bytes produce back-to-back pulses. The presented fields stay stable while `op_valid_o` is low.
- R9: After each handoff, the gathered prefix and extension state is empty, so the next instruction starts clean.
- R10: Bytes presented while `byte_valid_i` is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 0 = 16-bit default, 1 = 32-bit default, 2 = long mode, 3 = treated as 32-bit |
| byte_valid_i | input | 1 | `byte_i` carries a stream byte this cycle |
| byte_i | input | 8 | Stream byte |
| op_valid_o | output | 1 | One-cycle handoff pulse |
| op_byte_o | output | 8 | First opcode byte of the instruction |
| pfx_vec_o | output | 8 | Packed legacy prefix vector |
| rex_present_o | output | 1 | An extension byte was captured |
| rex_w_o | output | 1 | Extension W bit |
| rex_r_o | output | 1 | Extension R bit |
| rex_x_o | output | 1 | Extension X bit |
| rex_b_o | output | 1 | Extension B bit |
| op_size_o | output | 2 | Operand-size code: 1 = 16, 2 = 32, 3 = 64 |

## Verification
The stimulus includes instructions with no prefixes, with a lone 0x66, with a W-set extension byte, and with both 0x66 and W set. Together these separate the size-priority order from a plain flag lookup in all three modes. Chains of segment prefixes show that the last one wins. A stack of every flag prefix followed by a segment prefix shows that flags and the segment code do not clobber each other. Bytes 0x40–0x4F are sent in long and non-long modes to separate capture from opcode handoff. Back-to-back opcodes, idle cycles carrying prefix values, and a following clean instruction expose leftover state and pulse timing.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  localparam int BYTE_W  = 8;
  localparam int VEC_W   = 8;
  localparam int SEG_W   = 3;
  localparam int SIZE_W  = 2;
  localparam int MODE_W  = 2;
  // flag bit positions inside the prefix vector
  localparam int B_OSZ   = 3;
  localparam int B_ASZ   = 4;
  localparam int B_LOCK  = 5;
  localparam int B_REP   = 6;
  localparam int B_REPNE = 7;

  localparam logic [MODE_W-1:0] MODE_16 = 2'd0;
  localparam logic [MODE_W-1:0] MODE_32 = 2'd1;
  localparam logic [MODE_W-1:0] MODE_64 = 2'd2;

  typedef enum logic [2:0] {
    K_OPC, K_SEG, K_OSZ, K_ASZ, K_LOCK, K_REP, K_REPNE, K_REX
  } kind_e;

  typedef struct packed {
    logic seen;
    logic w;
    logic r;
    logic x;
    logic b;
  } rex_t;
endpackage

// File: rtl/pfx_classify.sv
module pfx_classify
  import pfx_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [MODE_W-1:0] mode_i,
  output kind_e             kind_o,
  output logic [SEG_W-1:0]  seg_o
);
  always_comb begin
    kind_o = K_OPC;
    seg_o  = '0;
    casez (byte_i)
      8'h2E: begin kind_o = K_SEG; seg_o = 3'd1; end
      8'h3E: begin kind_o = K_SEG; seg_o = 3'd2; end
      8'h26: begin kind_o = K_SEG; seg_o = 3'd3; end
      8'h64: begin kind_o = K_SEG; seg_o = 3'd4; end
      8'h65: begin kind_o = K_SEG; seg_o = 3'd5; end
      8'h36: begin kind_o = K_SEG; seg_o = 3'd6; end
      8'h66: kind_o = K_OSZ;
      8'h67: kind_o = K_ASZ;
      8'hF0: kind_o = K_LOCK;
      8'hF3: kind_o = K_REP;
      8'hF2: kind_o = K_REPNE;
      8'b0100_????: kind_o = (mode_i == MODE_64) ? K_REX : K_OPC;
      default: kind_o = K_OPC;
    endcase
  end
endmodule

// File: rtl/pfx_state.sv
module pfx_state
  import pfx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  kind_e             kind_i,
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [3:0]        nib_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [VEC_W-1:0]  vec_o,
  output rex_t              rex_o
);
  logic [VEC_W-1:0] vec_q, vec_d;
  rex_t             rex_q, rex_d;
  logic             en;
  logic             handoff;

  assign handoff = take_i && (kind_i == K_OPC);

  always_comb begin
    en    = take_i;
    vec_d = vec_q;
    rex_d = rex_q;
    if (handoff) begin
      vec_d = '0;
      rex_d = '0;
    end else begin
      case (kind_i)
        K_SEG:   vec_d[SEG_W-1:0] = seg_i;
        K_OSZ:   vec_d[B_OSZ]     = 1'b1;
        K_ASZ:   vec_d[B_ASZ]     = 1'b1;
        K_LOCK:  vec_d[B_LOCK]    = 1'b1;
        K_REP:   vec_d[B_REP]     = 1'b1;
        K_REPNE: vec_d[B_REPNE]   = 1'b1;
        K_REX:   rex_d = '{seen: 1'b1, w: nib_i[3], r: nib_i[2],
                           x: nib_i[1], b: nib_i[0]};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
      rex_q <= '0;
    end else if (en) begin
      vec_q <= vec_d;
      rex_q <= rex_d;
    end
  end

  assign vec_o = vec_q;
  assign rex_o = rex_q;

  // R9: state is empty the cycle after a handoff
  p_clean_after_handoff_r9: assert property (@(posedge clk) disable iff (!rst_n)
    handoff |=> (vec_q == '0 && rex_q == '0));

  // R3: a prefix byte never clears an already set flag
  p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && kind_i != K_OPC) |=>
      ((vec_q[VEC_W-1:B_OSZ] & $past(vec_q[VEC_W-1:B_OSZ])) == $past(vec_q[VEC_W-1:B_OSZ])));

  // R7: extension capture only starts in long mode
  p_rex_long_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rex_q.seen) |-> ($past(mode_i) == MODE_64));
endmodule

// File: rtl/pfx_opsize.sv
module pfx_opsize
  import pfx_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic              osz_i,
  input  logic              wide_i,
  output logic [SIZE_W-1:0] size_o
);
  always_comb begin
    case (mode_i)
      MODE_64: size_o = wide_i ? 2'd3 : (osz_i ? 2'd1 : 2'd2);
      MODE_16: size_o = osz_i ? 2'd2 : 2'd1;
      default: size_o = osz_i ? 2'd1 : 2'd2;
    endcase
  end
endmodule

// File: rtl/pfx_accum.sv
module pfx_accum
  import pfx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  output logic              op_valid_o,
  output logic [7:0]        op_byte_o,
  output logic [7:0]        pfx_vec_o,
  output logic              rex_present_o,
  output logic              rex_w_o,
  output logic              rex_r_o,
  output logic              rex_x_o,
  output logic              rex_b_o,
  output logic [1:0]        op_size_o
);
  kind_e              kind;
  logic [SEG_W-1:0]   seg;
  logic [VEC_W-1:0]   acc_vec;
  rex_t               acc_rex;
  logic [SIZE_W-1:0]  size_c;
  logic               handoff;

  logic               vld_q;
  logic [BYTE_W-1:0]  opc_q, opc_d;
  logic [VEC_W-1:0]   vec_q, vec_d;
  rex_t               rex_q, rex_d;
  logic [SIZE_W-1:0]  size_q, size_d;
  logic               out_en;

  pfx_classify u_classify (
    .byte_i (byte_i),
    .mode_i (mode_i),
    .kind_o (kind),
    .seg_o  (seg)
  );

  pfx_state u_state (
    .clk    (clk),
    .rst_n  (rst_n),
    .take_i (byte_valid_i),
    .kind_i (kind),
    .seg_i  (seg),
    .nib_i  (byte_i[3:0]),
    .mode_i (mode_i),
    .vec_o  (acc_vec),
    .rex_o  (acc_rex)
  );

  pfx_opsize u_opsize (
    .mode_i (mode_i),
    .osz_i  (acc_vec[B_OSZ]),
    .wide_i (acc_rex.seen && acc_rex.w),
    .size_o (size_c)
  );

  assign handoff = byte_valid_i && (kind == K_OPC);

  always_comb begin
    out_en = handoff;
    opc_d  = byte_i;
    vec_d  = acc_vec;
    rex_d  = acc_rex;
    size_d = size_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= handoff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opc_q  <= '0;
      vec_q  <= '0;
      rex_q  <= '0;
      size_q <= '0;
    end else if (out_en) begin
      opc_q  <= opc_d;
      vec_q  <= vec_d;
      rex_q  <= rex_d;
      size_q <= size_d;
    end
  end

  assign op_valid_o    = vld_q;
  assign op_byte_o     = opc_q;
  assign pfx_vec_o     = vec_q;
  assign rex_present_o = rex_q.seen;
  assign rex_w_o       = rex_q.w;
  assign rex_r_o       = rex_q.r;
  assign rex_x_o       = rex_q.x;
  assign rex_b_o       = rex_q.b;
  assign op_size_o     = size_q;

  // R8: a pulse only follows an accepted byte
  p_pulse_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_o |-> $past(byte_valid_i));

  // R8: presented fields hold between pulses
  p_hold_fields_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid_o |-> ($stable(pfx_vec_o) && $stable(op_size_o) && $stable(op_byte_o)));

  // R2: segment code 7 is never produced
  p_seg_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_vec_o[2:0] != 3'd7);

  // R4: every handed-off instruction carries a real size code
  p_size_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_o |-> (op_size_o != 2'd0));
endmodule

// File: tb/test_pfx_accum.sv
`timescale 1ns/1ps
module test_pfx_accum;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic       bv;
  logic [7:0] bi;
  logic       op_valid;
  logic [7:0] op_byte, pfx_vec;
  logic       rp, rw, rr, rx, rb;
  logic [1:0] op_size;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct { logic [22:0] v; string tag; } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  pfx_accum i_pfx_accum (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .byte_valid_i(bv), .byte_i(bi),
    .op_valid_o(op_valid), .op_byte_o(op_byte), .pfx_vec_o(pfx_vec),
    .rex_present_o(rp), .rex_w_o(rw), .rex_r_o(rr), .rex_x_o(rx), .rex_b_o(rb),
    .op_size_o(op_size)
  );

  function automatic logic [22:0] seen_now();
    return {pfx_vec, rp, rw, rr, rx, rb, op_size, op_byte};
  endfunction

  task automatic cmp(input logic [22:0] act, input logic [22:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected item: vector, {seen,w,r,x,b}, size, opcode
  task automatic expect_op(input logic [7:0] v, input logic [4:0] r,
                           input logic [1:0] s, input logic [7:0] o, input string tag);
    exp_t e;
    e.v = {v, r, s, o};
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic put(input logic [7:0] b);
    bv = 1'b1;
    bi = b;
    @(posedge clk); #1;
    bv = 1'b0;
  endtask

  task automatic idle(input int n, input logic [7:0] junk);
    bi = junk;
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  // monitor: pops the scoreboard on every pulse
  always @(negedge clk) begin
    if (rst_n === 1'b1 && op_valid === 1'b1) begin
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8 unexpected pulse actual=%h expected=none", seen_now());
      end else begin
        exp_t e;
        e = q.pop_front();
        cmp(seen_now(), e.v, e.tag);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bv = 1'b0; bi = 8'h00; mode = 2'd2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp({op_valid, seen_now()}, 24'h0, "R1 reset");
    rst_n = 1'b1;
    @(posedge clk); #1;

    mode = 2'd2;
    expect_op(8'h00, 5'b11000, 2'd3, 8'h89, "R7 R4 rex.w");
    put(8'h48); put(8'h89);
    expect_op(8'h08, 5'b11000, 2'd3, 8'h01, "R4 W over 0x66");
    put(8'h66); put(8'h48); put(8'h01);
    expect_op(8'h08, 5'b00000, 2'd1, 8'h01, "R4 R9 osz only");
    put(8'h66); put(8'h01);
    expect_op(8'h00, 5'b00000, 2'd2, 8'h01, "R4 R9 plain");
    put(8'h01);
    expect_op(8'h05, 5'b00000, 2'd2, 8'h8B, "R2 last seg wins");
    put(8'h2E); put(8'h3E); put(8'h65); put(8'h8B);
    expect_op(8'hFB, 5'b00000, 2'd1, 8'h90, "R3 all flags plus seg");
    put(8'hF0); put(8'hF3); put(8'hF2); put(8'h67); put(8'h66); put(8'h26); put(8'h90);
    expect_op(8'h06, 5'b00000, 2'd2, 8'h90, "R2 ss overwrite fs");
    put(8'h64); put(8'h36); put(8'h90);
    expect_op(8'h00, 5'b10101, 2'd2, 8'hC3, "R7 later rex replaces");
    put(8'h4F); put(8'h45); put(8'hC3);
    expect_op(8'h08, 5'b10100, 2'd1, 8'hC7, "R4 rex without W");
    put(8'h44); put(8'h66); put(8'hC7);
    expect_op(8'h00, 5'b00000, 2'd2, 8'h90, "R8 back to back a");
    expect_op(8'h00, 5'b00000, 2'd2, 8'h91, "R8 back to back b");
    put(8'h90); put(8'h91);

    // hold while idle; junk prefixes on the bus must be ignored
    idle(1, 8'h66);
    @(negedge clk);
    cmp({op_valid, seen_now()}, {1'b0, 8'h00, 5'b00000, 2'd2, 8'h91}, "R8 hold");
    @(posedge clk); #1;
    idle(3, 8'h66);
    expect_op(8'h00, 5'b00000, 2'd2, 8'h90, "R10 idle bytes ignored");
    put(8'h90);

    mode = 2'd1;
    expect_op(8'h08, 5'b00000, 2'd1, 8'h40, "R5 R7 0x40 as opcode");
    put(8'h66); put(8'h40);
    expect_op(8'h00, 5'b00000, 2'd2, 8'h41, "R5 plain");
    put(8'h41);
    mode = 2'd0;
    expect_op(8'h08, 5'b00000, 2'd2, 8'h90, "R6 osz gives 32");
    put(8'h66); put(8'h90);
    expect_op(8'h00, 5'b00000, 2'd1, 8'h4B, "R6 R7 plain 16");
    put(8'h4B);
    mode = 2'd3;
    expect_op(8'h08, 5'b00000, 2'd1, 8'h90, "R5 mode 3 as 32");
    put(8'h66); put(8'h90);

    idle(4, 8'h00);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R8 missing pulses actual=%0d expected=0", q.size());
    end
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule